// File: doc/BRIEF.md
# Load Address and Extension Unit

This unit sits in the memory stage of a processor pipeline. For every load or store it forms the effective address by adding a base register value to a signed 16-bit displacement, derives the byte-lane write enables for the access size, and flags accesses whose address does not match the natural alignment of that size. Trapping on misaligned accesses is left to the surrounding logic.

For loads, the same unit takes the 32-bit word read from memory. It picks the addressed byte or halfword lane, with memory treated as little-endian. It then widens that value to 32 bits, either by copying its top bit or by filling with zeros, according to an unsigned-variant flag.

All results appear on registered outputs one clock after a request is presented.

Top module: `lx_unit`

## Requirements
- R1: One cycle after a request, `eff_addr` equals `base` plus `offset` sign-extended to 32 bits, with the sum taken modulo 2^32.
- R2: `byte_en` is 4'b0001 shifted left by `eff_addr[1:0]` for a byte access. For a halfword access it is 4'b0011 shifted left by `eff_addr[1:0]`, keeping only the low 4 bits. For a word access it is 4'b1111. Bit k enables memory bits [8k+7:8k].
- R3: `misaligned` is 1 for a halfword access with `eff_addr[0]`=1 and for a word access with `eff_addr[1:0]`≠0. It is 0 in every other case, including all byte accesses.
- R4: For a signed byte load (`is_unsigned`=0), `wb_data` is `rdata[8*a+7:8*a]`, where a=`eff_addr[1:0]`, with its bit 7 copied into bits 31:8.
- R5: For an unsigned byte load (`is_unsigned`=1), `wb_data` is the same selected byte with bits 31:8 cleared.
- R6: For a signed halfword load, `wb_data` is `rdata[15:0]` when `eff_addr[1]`=0 and `rdata[31:16]` when it is 1, with its bit 15 copied into bits 31:16.
- R7: For an unsigned halfword load, `wb_data` is the same selected halfword with bits 31:16 cleared.
- R8: For a word access, `wb_data` equals `rdata`, and `is_unsigned` has no effect.
- R9: The access size is encoded on `size` as 2'b00 byte, 2'b01 halfword and 2'b10 word. The code 2'b11 behaves exactly as word.
- R10: `out_valid` is `req_valid` delayed by one clock, and outputs change only when a request is captured. While `rst_n` is low at a clock edge, every output is cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| base | input | 32 | Base register value |
| offset | input | 16 | Signed displacement |
| size | input | 2 | Access size code |
| is_unsigned | input | 1 | 1 selects zero extension of loaded data |
| rdata | input | 32 | Word read from memory for this access |
| out_valid | output | 1 | Registered results are valid |
| eff_addr | output | 32 | Effective address |
| byte_en | output | 4 | Byte-lane enables |
| misaligned | output | 1 | Address does not fit the access size |
| wb_data | output | 32 | Extended load value for write-back |

## Verification
The bench builds the unit with its default widths: a 32-bit data path and a 16-bit displacement. With these widths it can reach every byte lane and both halfword lanes. It can also reach negative displacements that wrap the address below zero, and a positive base near the top of memory that wraps past it. The vectors pair lanes holding set and clear top bits with both values of the unsigned flag, and they include the reserved size code and misaligned halfword and word addresses.

// File: rtl/lx_pkg.sv
// Shared types for the load address and extension unit.
// Assumes the size code on the top port is two bits wide.
package lx_pkg;

    typedef enum logic [1:0] {
        ACC_BYTE = 2'b00,
        ACC_HALF = 2'b01,
        ACC_WORD = 2'b10,
        ACC_RSVD = 2'b11
    } acc_size_e;

    // Map a raw size code onto an effective size; the reserved code acts as word.
    function automatic acc_size_e to_eff(input logic [1:0] code);
        acc_size_e r;
        case (code)
            2'b00:   r = ACC_BYTE;
            2'b01:   r = ACC_HALF;
            default: r = ACC_WORD;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lx_addr_gen.sv
// Effective address adder: base plus a sign-extended displacement.
// Assumes OW < AW; the sum wraps modulo 2^AW.
module lx_addr_gen #(
    parameter int AW = 32,
    parameter int OW = 16
) (
    input  logic [AW-1:0] base,
    input  logic [OW-1:0] ofs,
    output logic [AW-1:0] ea
);
    localparam int EXT = AW - OW;

    logic [AW-1:0] ofs_ext;

    // Widen the displacement by copying its top bit, then add.
    always_comb begin
        ofs_ext = {{EXT{ofs[OW-1]}}, ofs};
        ea      = base + ofs_ext;
    end
endmodule

// File: rtl/lx_lane_ctrl.sv
// Byte-enable and alignment decode from the low address bits.
// Assumes at least two byte lanes; half enables shift by the full lane index.
module lx_lane_ctrl
    import lx_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [$clog2(DW/8)-1:0] lane,
    input  acc_size_e               sz,
    output logic [DW/8-1:0]         be,
    output logic                    misalign
);
    localparam int NL = DW / 8;

    localparam logic [NL-1:0] ONE_LANE = {{(NL-1){1'b0}}, 1'b1};
    localparam logic [NL-1:0] TWO_LANE = {{(NL-2){1'b0}}, 2'b11};

    // Decode lane enables and alignment for the effective access size.
    always_comb begin
        case (sz)
            ACC_BYTE: begin
                be       = ONE_LANE << lane;
                misalign = 1'b0;
            end
            ACC_HALF: begin
                be       = TWO_LANE << lane;
                misalign = lane[0];
            end
            default: begin
                be       = '1;
                misalign = |lane;
            end
        endcase
    end
endmodule

// File: rtl/lx_load_fmt.sv
// Loaded-data formatter: picks a little-endian lane and extends it.
// Assumes DW is a multiple of 16; halfword lane index is lane[msb:1].
module lx_load_fmt
    import lx_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0]           rdata,
    input  logic [$clog2(DW/8)-1:0] lane,
    input  acc_size_e               sz,
    input  logic                    uns,
    output logic [DW-1:0]           wb
);
    localparam int NL = DW / 8;
    localparam int NH = DW / 16;
    localparam int LB = $clog2(NL);

    logic [7:0]  byte_slot [NL];
    logic [15:0] half_slot [NH];

    genvar g;
    generate
        for (g = 0; g < NL; g++) begin : g_bytes
            assign byte_slot[g] = rdata[8*g +: 8];
        end
        for (g = 0; g < NH; g++) begin : g_halves
            assign half_slot[g] = rdata[16*g +: 16];
        end
    endgenerate

    logic [7:0]  sel_b;
    logic [15:0] sel_h;
    logic        fill_b;
    logic        fill_h;

    // Select the addressed lane, then fill the upper bits per the flag.
    always_comb begin
        sel_b  = byte_slot[lane];
        sel_h  = half_slot[lane[LB-1:1]];
        fill_b = ~uns & sel_b[7];
        fill_h = ~uns & sel_h[15];
        case (sz)
            ACC_BYTE: wb = {{(DW-8){fill_b}}, sel_b};
            ACC_HALF: wb = {{(DW-16){fill_h}}, sel_h};
            default:  wb = rdata;
        endcase
    end
endmodule

// File: rtl/lx_unit.sv
// Load address and extension unit, top level.
// Computes the effective address, byte enables and misalignment flag,
// formats the loaded word, and registers everything for one cycle.
// Assumes rdata belongs to the request presented in the same cycle.
module lx_unit
    import lx_pkg::*;
#(
    parameter int DW = 32,
    parameter int OW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [DW-1:0]   base,
    input  logic [OW-1:0]   offset,
    input  logic [1:0]      size,
    input  logic            is_unsigned,
    input  logic [DW-1:0]   rdata,
    output logic            out_valid,
    output logic [DW-1:0]   eff_addr,
    output logic [DW/8-1:0] byte_en,
    output logic            misaligned,
    output logic [DW-1:0]   wb_data
);
    localparam int NL = DW / 8;
    localparam int LB = $clog2(NL);

    acc_size_e       sz_eff;
    logic [DW-1:0]   ea_c;
    logic [NL-1:0]   be_c;
    logic            mis_c;
    logic [DW-1:0]   wb_c;
    acc_size_e       sz_q;
    logic            uns_q;

    // Normalise the size code so the reserved value acts as word.
    always_comb sz_eff = to_eff(size);

    lx_addr_gen #(.AW(DW), .OW(OW)) u_addr (
        .base (base),
        .ofs  (offset),
        .ea   (ea_c)
    );

    lx_lane_ctrl #(.DW(DW)) u_lane (
        .lane     (ea_c[LB-1:0]),
        .sz       (sz_eff),
        .be       (be_c),
        .misalign (mis_c)
    );

    lx_load_fmt #(.DW(DW)) u_fmt (
        .rdata (rdata),
        .lane  (ea_c[LB-1:0]),
        .sz    (sz_eff),
        .uns   (is_unsigned),
        .wb    (wb_c)
    );

    // Output stage: capture results of an accepted request, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            eff_addr   <= '0;
            byte_en    <= '0;
            misaligned <= 1'b0;
            wb_data    <= '0;
            sz_q       <= ACC_BYTE;
            uns_q      <= 1'b0;
        end else begin
            out_valid <= req_valid;
            if (req_valid) begin
                eff_addr   <= ea_c;
                byte_en    <= be_c;
                misaligned <= mis_c;
                wb_data    <= wb_c;
                sz_q       <= sz_eff;
                uns_q      <= is_unsigned;
            end
        end
    end

    AST_EA_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> eff_addr == $past(base) + {{(DW-OW){$past(offset[OW-1])}}, $past(offset)}); // R1

    AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && sz_q == ACC_BYTE) |-> $countones(byte_en) == 1); // R2

    AST_WORD_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && sz_q == ACC_WORD) |-> byte_en == '1); // R2

    AST_BYTE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && sz_q == ACC_BYTE) |-> !misaligned); // R3

    AST_SBYTE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && sz_q == ACC_BYTE && !uns_q)
            |-> ($countones(wb_data[DW-1:7]) == 0 || $countones(wb_data[DW-1:7]) == DW-7)); // R4

    AST_UBYTE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && sz_q == ACC_BYTE && uns_q) |-> wb_data[DW-1:8] == '0); // R5

    AST_UHALF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && sz_q == ACC_HALF && uns_q) |-> wb_data[DW-1:16] == '0); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!out_valid && $stable(eff_addr) && $stable(wb_data))); // R10
endmodule

// File: tb/lx_unit_test.sv
// Scoreboard bench: the driver queues expected results, the monitor compares.
module lx_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] base = '0;
    logic [15:0] offset = '0;
    logic [1:0]  size = '0;
    logic        is_unsigned = 1'b0;
    logic [31:0] rdata = '0;
    logic        out_valid;
    logic [31:0] eff_addr;
    logic [3:0]  byte_en;
    logic        misaligned;
    logic [31:0] wb_data;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    typedef struct {
        logic [31:0] ea;
        logic [3:0]  be;
        logic        mis;
        logic [31:0] wb;
        string       req;
    } exp_t;

    exp_t sb[$];

    always #2.5 clk = ~clk;

    lx_unit uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .base(base),
        .offset(offset), .size(size), .is_unsigned(is_unsigned), .rdata(rdata),
        .out_valid(out_valid), .eff_addr(eff_addr), .byte_en(byte_en),
        .misaligned(misaligned), .wb_data(wb_data)
    );

    // Build the expected result from the requirements and queue the request.
    task automatic drive(input logic [31:0] b, input logic [15:0] o, input logic [1:0] s,
                         input logic u, input logic [31:0] d, input string req);
        exp_t e;
        logic [7:0]  bt;
        logic [15:0] hw;
        e.ea = b + {{16{o[15]}}, o};
        bt = d[8*e.ea[1:0] +: 8];
        hw = e.ea[1] ? d[31:16] : d[15:0];
        if (s == 2'b00) begin
            e.be  = 4'b0001 << e.ea[1:0];
            e.mis = 1'b0;
            e.wb  = u ? {24'h0, bt} : {{24{bt[7]}}, bt};
        end else if (s == 2'b01) begin
            e.be  = 4'(8'b0000_0011 << e.ea[1:0]);
            e.mis = e.ea[0];
            e.wb  = u ? {16'h0, hw} : {{16{hw[15]}}, hw};
        end else begin
            e.be  = 4'hF;
            e.mis = (e.ea[1:0] != 2'b00);
            e.wb  = d;
        end
        e.req = req;
        @(negedge clk);
        base = b; offset = o; size = s; is_unsigned = u; rdata = d; req_valid = 1'b1;
        sb.push_back(e);
    endtask

    // Monitor: compare each valid output against the head of the queue.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            n_checks++;
            if (sb.size() == 0) begin
                n_fails++;
                $display("FAIL R10: out_valid=1 expected 0 (no pending request)");
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (eff_addr !== e.ea || byte_en !== e.be || misaligned !== e.mis || wb_data !== e.wb) begin
                    n_fails++;
                    $display("FAIL %s: ea=%h be=%b mis=%b wb=%h expected ea=%h be=%b mis=%b wb=%h",
                             e.req, eff_addr, byte_en, misaligned, wb_data, e.ea, e.be, e.mis, e.wb);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        // R10: outputs cleared under reset, even with a request present.
        base = 32'hDEAD_BEEF; rdata = 32'hFFFF_FFFF; size = 2'b10; req_valid = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0 || eff_addr !== 32'h0 || byte_en !== 4'h0 || misaligned !== 1'b0 || wb_data !== 32'h0) begin
            n_fails++;
            $display("FAIL R10: reset outputs v=%b ea=%h be=%b mis=%b wb=%h expected all 0",
                     out_valid, eff_addr, byte_en, misaligned, wb_data);
        end
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R4: signed bytes from each lane, positive displacement.
        drive(32'h0000_1000, 16'h0000, 2'b00, 1'b0, 32'h80_7F_01_F6, "R4");
        drive(32'h0000_1000, 16'h0001, 2'b00, 1'b0, 32'h80_7F_01_F6, "R4");
        drive(32'h0000_1000, 16'h0002, 2'b00, 1'b0, 32'h80_7F_01_F6, "R4");
        drive(32'h0000_1000, 16'h0003, 2'b00, 1'b0, 32'h80_7F_01_F6, "R4");
        // R5: unsigned bytes with the top bit set.
        drive(32'h0000_2000, 16'h0000, 2'b00, 1'b1, 32'h80_7F_01_F6, "R5");
        drive(32'h0000_2000, 16'h0003, 2'b00, 1'b1, 32'h80_7F_01_F6, "R5");
        // R1: negative displacement wraps below zero; R2 halfword enables.
        drive(32'h0000_0002, 16'hFFFC, 2'b01, 1'b0, 32'h8001_7FFE, "R1");
        drive(32'hFFFF_FFF0, 16'h0014, 2'b10, 1'b0, 32'hCAFE_F00D, "R1");
        drive(32'h0021_0000, 16'hF000, 2'b10, 1'b0, 32'h1234_5678, "R1");
        // R6: signed halfwords from both lanes.
        drive(32'h0000_3000, 16'h0000, 2'b01, 1'b0, 32'h8001_7FFE, "R6");
        drive(32'h0000_3000, 16'h0002, 2'b01, 1'b0, 32'h8001_7FFE, "R6");
        drive(32'h0000_3000, 16'h0000, 2'b01, 1'b0, 32'h0001_9ABC, "R6");
        // R7: unsigned halfwords.
        drive(32'h0000_3000, 16'h0000, 2'b01, 1'b1, 32'h0001_9ABC, "R7");
        drive(32'h0000_3000, 16'h0002, 2'b01, 1'b1, 32'h8001_7FFE, "R7");
        // R8: word ignores the unsigned flag.
        drive(32'h0000_4000, 16'h0004, 2'b10, 1'b1, 32'h8765_4321, "R8");
        drive(32'h0000_4000, 16'h0004, 2'b10, 1'b0, 32'h8765_4321, "R8");
        // R3/R2: misaligned halfword at lanes 1 and 3, misaligned words.
        drive(32'h0000_5000, 16'h0001, 2'b01, 1'b0, 32'hAABB_CCDD, "R3");
        drive(32'h0000_5000, 16'h0003, 2'b01, 1'b1, 32'hAABB_CCDD, "R3");
        drive(32'h0000_5000, 16'h0002, 2'b10, 1'b0, 32'hAABB_CCDD, "R3");
        drive(32'h0000_5000, 16'hFFFF, 2'b10, 1'b0, 32'hAABB_CCDD, "R3");
        // R9: reserved size code behaves as word.
        drive(32'h0000_6000, 16'h0001, 2'b11, 1'b1, 32'hF0F0_0F0F, "R9");
        drive(32'h0000_6000, 16'h0000, 2'b11, 1'b0, 32'h8000_0001, "R9");
        @(negedge clk);
        req_valid = 1'b0;
        // R10: idle inputs must not change the outputs or raise out_valid.
        base = 32'h1111_1111; rdata = 32'h2222_2222; size = 2'b00;
        repeat (3) @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0 || eff_addr !== 32'h0000_6000 || wb_data !== 32'h8000_0001) begin
            n_fails++;
            $display("FAIL R10: idle v=%b ea=%h wb=%h expected v=0 ea=00006000 wb=80000001",
                     out_valid, eff_addr, wb_data);
        end
        n_checks++;
        if (sb.size() != 0) begin
            n_fails++;
            $display("FAIL R10: %0d results missing, expected 0", sb.size());
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule